// File: doc/BRIEF.md
# Register-Pair Data-Move Execution Unit

This unit carries out five 16-bit data-move operations on a small byte-wide register file. The file holds an accumulator, six general bytes that pair up as BC, DE and HL, a 16-bit stack pointer and a carry flag. The unit is started with an operation code and a pair select, and raises a one-clock completion pulse when the operation finishes. While it works it holds `busy` high and ignores new starts. Byte reads and writes go out through a request/acknowledge memory port. A request stays up, with address, direction and data held steady, until the memory acknowledges it.

Two operations touch memory. The indirect store writes the accumulator to the address held in BC or DE. The stack-top exchange reads the bytes at SP and SP+1 and writes the old L and old H back to those locations. The other three operations act on the registers alone: swapping HL with DE, loading the stack pointer from HL, and adding a chosen pair into HL with a carry out. A register write port lets the surrounding core load any register while the unit is idle.

Top module: `rpx_exec_unit`

## Requirements
- R1: Operation code 0 swaps H with D and L with E in one operation.
- R2: Operation code 1 copies H to the stack pointer's high byte and L to its low byte, and leaves H and L unchanged.
- R3: Operation code 2 issues exactly four memory steps in this order: read SP, read SP+1, write old L to SP, write old H to SP+1. The stack pointer is unchanged afterwards.
- R4: After operation code 2, L holds the byte read from SP and H holds the byte read from SP+1.
- R5: The address SP+1 wraps modulo 65536, so SP = 0xFFFF uses 0x0000 as its second address.
- R6: Operation code 3 writes the accumulator to address BC when pair_sel bit 0 is 0, and to DE when it is 1. The accumulator is unchanged.
- R7: Operation code 4 adds the pair picked by pair_sel (0 = BC, 1 = DE, 2 = HL, 3 = SP) to HL modulo 65536. The result goes to HL and the carry takes the carry out of bit 15.
- R8: `done` is high for exactly one clock when an operation completes. `busy` is high from the cycle after a start is accepted until that completion. A start while busy is ignored.
- R9: A memory request keeps its address, write enable and write data steady until it is acknowledged. No request is made while idle.
- R10: After reset, busy, done and mem_req are low, and every register and the carry are zero.
- R11: The register write port (index 0 = A, 1 = B, 2 = C, 3 = D, 4 = E, 5 = H, 6 = L, 7 = SP, 8 = carry from data bit 0) loads a register when the unit is idle. It is ignored while busy.
- R12: Operation codes 5 to 7 complete with a done pulse and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request for an operation |
| op | input | 3 | Operation code |
| pair_sel | input | 2 | Register-pair select |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| reg_wr_en | input | 1 | Register write port enable |
| reg_wr_idx | input | 4 | Register write port index |
| reg_wr_data | input | 16 | Register write port data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| reg_a | output | 8 | Accumulator |
| reg_b | output | 8 | Register B |
| reg_c | output | 8 | Register C |
| reg_d | output | 8 | Register D |
| reg_e | output | 8 | Register E |
| reg_h | output | 8 | Register H |
| reg_l | output | 8 | Register L |
| reg_sp | output | 16 | Stack pointer |
| flag_cy | output | 1 | Carry flag |

## Verification
The hardest situation to reach from the ports is a start pulse, together with a register write, that arrives in the middle of a stack-top exchange that is still waiting on memory. The bench's memory model holds off its acknowledge for several cycles. That keeps the unit busy long enough to inject the conflicting stimulus. The bench then checks that D, E and B keep their values and that no second completion follows. The wrap of the second stack address is reached by loading SP with 0xFFFF through the register port before the exchange.

// File: rtl/rpx_pkg.sv
// Package: shared operation codes, sequencer states and register indices
// for the register-pair data-move execution unit.
package rpx_pkg;
    localparam logic [2:0] OP_XCHG  = 3'd0;
    localparam logic [2:0] OP_SPLD  = 3'd1;
    localparam logic [2:0] OP_STKX  = 3'd2;
    localparam logic [2:0] OP_STIND = 3'd3;
    localparam logic [2:0] OP_PADD  = 3'd4;

    localparam logic [3:0] IDX_A  = 4'd0;
    localparam logic [3:0] IDX_B  = 4'd1;
    localparam logic [3:0] IDX_C  = 4'd2;
    localparam logic [3:0] IDX_D  = 4'd3;
    localparam logic [3:0] IDX_E  = 4'd4;
    localparam logic [3:0] IDX_H  = 4'd5;
    localparam logic [3:0] IDX_L  = 4'd6;
    localparam logic [3:0] IDX_SP = 4'd7;
    localparam logic [3:0] IDX_CY = 4'd8;

    typedef enum logic [2:0] {
        S_IDLE, S_EXEC, S_RD0, S_RD1, S_WR0, S_WR1, S_STORE
    } seq_state_t;
endpackage

// File: rtl/rpx_add16.sv
// Module: plain W-bit adder with carry out, used for the pair add.
// Assumes both operands are unsigned; the sum wraps modulo 2**W.
module rpx_add16 #(
    parameter int W = 16
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum,
    output logic         cout
);
    // Widened add so the carry out falls into the top bit.
    always_comb begin
        {cout, sum} = {1'b0, opa} + {1'b0, opb};
    end
endmodule

// File: rtl/rpx_regfile.sv
// Module: byte register file (A, B, C, D, E, H, L), stack pointer and carry.
// Assumes the sequencer's commands and the external write port never act
// in the same cycle (the top gates the port with busy).
module rpx_regfile #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_we,
    input  logic [3:0]      ext_idx,
    input  logic [2*DW-1:0] ext_data,
    input  logic            cmd_xchg,
    input  logic            cmd_spld,
    input  logic            cmd_hl_we,
    input  logic [2*DW-1:0] cmd_hl_val,
    input  logic            cmd_cy_we,
    input  logic            cmd_cy_val,
    output logic [DW-1:0]   a,
    output logic [DW-1:0]   b,
    output logic [DW-1:0]   c,
    output logic [DW-1:0]   d,
    output logic [DW-1:0]   e,
    output logic [DW-1:0]   h,
    output logic [DW-1:0]   l,
    output logic [2*DW-1:0] sp,
    output logic            cy
);
    import rpx_pkg::*;
    localparam int AW = 2 * DW;

    // Register update: reset, sequencer commands, then external writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a  <= '0; b <= '0; c <= '0; d <= '0;
            e  <= '0; h <= '0; l <= '0;
            sp <= '0; cy <= 1'b0;
        end else begin
            if (cmd_xchg) begin
                h <= d; l <= e; d <= h; e <= l;
            end
            if (cmd_spld) sp <= {h, l};
            if (cmd_hl_we) {h, l} <= cmd_hl_val;
            if (cmd_cy_we) cy <= cmd_cy_val;
            if (ext_we) begin
                case (ext_idx)
                    IDX_A:   a  <= ext_data[DW-1:0];
                    IDX_B:   b  <= ext_data[DW-1:0];
                    IDX_C:   c  <= ext_data[DW-1:0];
                    IDX_D:   d  <= ext_data[DW-1:0];
                    IDX_E:   e  <= ext_data[DW-1:0];
                    IDX_H:   h  <= ext_data[DW-1:0];
                    IDX_L:   l  <= ext_data[DW-1:0];
                    IDX_SP:  sp <= ext_data[AW-1:0];
                    IDX_CY:  cy <= ext_data[0];
                    default: ;
                endcase
            end
        end
    end

    // R2: loading SP from HL must leave H and L as they were.
    a_r2_hl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_spld |=> $stable({h, l}));
endmodule

// File: rtl/rpx_seq.sv
// Module: operation sequencer. Accepts a start when idle, runs register-only
// operations in one execute cycle and memory operations as acknowledged
// steps, then pulses done. Assumes mem_rdata is valid in the ack cycle.
module rpx_seq #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [1:0]      pair_sel,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [DW-1:0]   c,
    input  logic [DW-1:0]   d,
    input  logic [DW-1:0]   e,
    input  logic [DW-1:0]   h,
    input  logic [DW-1:0]   l,
    input  logic [2*DW-1:0] sp,
    input  logic [2*DW-1:0] sum,
    input  logic            cout,
    output logic [2*DW-1:0] add_rhs,
    output logic            cmd_xchg,
    output logic            cmd_spld,
    output logic            cmd_hl_we,
    output logic [2*DW-1:0] cmd_hl_val,
    output logic            cmd_cy_we,
    output logic            cmd_cy_val,
    output logic            mem_req,
    output logic            mem_we,
    output logic [2*DW-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack,
    output logic            busy,
    output logic            done
);
    import rpx_pkg::*;
    localparam int AW = 2 * DW;

    seq_state_t      state;
    logic [2:0]      op_q;
    logic [1:0]      sel_q;
    logic [DW-1:0]   tmp_lo;
    logic [DW-1:0]   tmp_hi;
    logic [AW-1:0]   sp_next;
    logic            finish;

    assign sp_next = sp + AW'(1);
    assign busy    = (state != S_IDLE);

    // Add operand: the pair named by the latched select.
    always_comb begin
        case (sel_q)
            2'd0:    add_rhs = {b, c};
            2'd1:    add_rhs = {d, e};
            2'd2:    add_rhs = {h, l};
            default: add_rhs = sp;
        endcase
    end

    // Memory port drive for the current step.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_RD0:   begin mem_req = 1'b1; mem_addr = sp; end
            S_RD1:   begin mem_req = 1'b1; mem_addr = sp_next; end
            S_WR0:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp;      mem_wdata = l; end
            S_WR1:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_next; mem_wdata = h; end
            S_STORE: begin mem_req = 1'b1; mem_we = 1'b1;
                           mem_addr = sel_q[0] ? {d, e} : {b, c}; mem_wdata = a; end
            default: ;
        endcase
    end

    // Register commands issued on the completing cycle.
    always_comb begin
        cmd_xchg   = (state == S_EXEC) && (op_q == OP_XCHG);
        cmd_spld   = (state == S_EXEC) && (op_q == OP_SPLD);
        cmd_cy_we  = (state == S_EXEC) && (op_q == OP_PADD);
        cmd_cy_val = cout;
        cmd_hl_we  = cmd_cy_we || ((state == S_WR1) && mem_ack);
        cmd_hl_val = (state == S_WR1) ? {tmp_hi, tmp_lo} : sum;
        finish     = (state == S_EXEC) ||
                     (((state == S_WR1) || (state == S_STORE)) && mem_ack);
    end

    // State machine, operand latches and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= '0;
            sel_q  <= '0;
            tmp_lo <= '0;
            tmp_hi <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    op_q  <= op;
                    sel_q <= pair_sel;
                    case (op)
                        OP_STKX:  state <= S_RD0;
                        OP_STIND: state <= S_STORE;
                        default:  state <= S_EXEC;
                    endcase
                end
                S_EXEC:  state <= S_IDLE;
                S_RD0:   if (mem_ack) begin tmp_lo <= mem_rdata; state <= S_RD1; end
                S_RD1:   if (mem_ack) begin tmp_hi <= mem_rdata; state <= S_WR0; end
                S_WR0:   if (mem_ack) state <= S_WR1;
                S_WR1:   if (mem_ack) state <= S_IDLE;
                S_STORE: if (mem_ack) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Completion pulse, registered so it lines up with the updated registers.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish;
    end

    // R8: completion lasts a single clock.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: the unit is free again when it reports completion.
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: an unacknowledged request holds steady.
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
    // R9: no memory traffic while idle.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    // R3: the stack pointer does not move during memory steps.
    a_r3_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (state != S_STORE)) |=> $stable(sp));
endmodule

// File: rtl/rpx_exec_unit.sv
// Module: top of the register-pair data-move execution unit. Ties the
// sequencer, register file and adder together and blocks the register
// write port while an operation is in progress.
module rpx_exec_unit #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [1:0]      pair_sel,
    output logic            busy,
    output logic            done,
    input  logic            reg_wr_en,
    input  logic [3:0]      reg_wr_idx,
    input  logic [2*DW-1:0] reg_wr_data,
    output logic            mem_req,
    output logic            mem_we,
    output logic [2*DW-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack,
    output logic [DW-1:0]   reg_a,
    output logic [DW-1:0]   reg_b,
    output logic [DW-1:0]   reg_c,
    output logic [DW-1:0]   reg_d,
    output logic [DW-1:0]   reg_e,
    output logic [DW-1:0]   reg_h,
    output logic [DW-1:0]   reg_l,
    output logic [2*DW-1:0] reg_sp,
    output logic            flag_cy
);
    localparam int AW = 2 * DW;

    logic          ext_we;
    logic [AW-1:0] add_rhs, sum, cmd_hl_val;
    logic          cout, cmd_xchg, cmd_spld, cmd_hl_we, cmd_cy_we, cmd_cy_val;

    // Register port is honoured only while idle.
    assign ext_we = reg_wr_en && !busy;

    rpx_add16 #(.W(AW)) u_add (
        .opa(AW'({reg_h, reg_l})), .opb(add_rhs), .sum(sum), .cout(cout)
    );

    rpx_regfile #(.DW(DW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ext_we(ext_we), .ext_idx(reg_wr_idx), .ext_data(reg_wr_data),
        .cmd_xchg(cmd_xchg), .cmd_spld(cmd_spld),
        .cmd_hl_we(cmd_hl_we), .cmd_hl_val(cmd_hl_val),
        .cmd_cy_we(cmd_cy_we), .cmd_cy_val(cmd_cy_val),
        .a(reg_a), .b(reg_b), .c(reg_c), .d(reg_d), .e(reg_e),
        .h(reg_h), .l(reg_l), .sp(reg_sp), .cy(flag_cy)
    );

    rpx_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pair_sel(pair_sel),
        .a(reg_a), .b(reg_b), .c(reg_c), .d(reg_d), .e(reg_e),
        .h(reg_h), .l(reg_l), .sp(reg_sp), .sum(sum), .cout(cout),
        .add_rhs(add_rhs), .cmd_xchg(cmd_xchg), .cmd_spld(cmd_spld),
        .cmd_hl_we(cmd_hl_we), .cmd_hl_val(cmd_hl_val),
        .cmd_cy_we(cmd_cy_we), .cmd_cy_val(cmd_cy_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done)
    );

    // R11: a blocked register write leaves the accumulator untouched.
    a_r11_port_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr_en && !done) |=> $stable(reg_a));
endmodule

// File: tb/rpx_exec_unit_tb_top.sv
// Bench: table-driven pair-add vectors, then directed tests for the other
// operations, memory ordering, wrap, busy blocking and reset.
module rpx_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  pair_sel = '0;
    logic        busy, done;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_idx = '0;
    logic [15:0] reg_wr_data = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [7:0]  reg_a, reg_b, reg_c, reg_d, reg_e, reg_h, reg_l;
    logic [15:0] reg_sp;
    logic        flag_cy;

    int checks = 0;
    int fails  = 0;
    int lat    = 0;
    int wcnt   = 0;
    logic [7:0]  mem [0:255];
    logic [15:0] log_addr [0:7];
    logic        log_we   [0:7];
    logic [7:0]  log_data [0:7];
    int          log_n = 0;

    always #5 clk = ~clk;

    rpx_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pair_sel(pair_sel),
        .busy(busy), .done(done), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
        .reg_wr_data(reg_wr_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
        .reg_d(reg_d), .reg_e(reg_e), .reg_h(reg_h), .reg_l(reg_l),
        .reg_sp(reg_sp), .flag_cy(flag_cy)
    );

    // Memory model: acknowledges after lat idle cycles, logs every step.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack = 1'b1;
                mem_rdata = mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
                if (log_n < 8) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n]   = mem_we;
                    log_data[log_n] = mem_wdata;
                end
                log_n++;
            end else wcnt++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [15:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic run(input logic [2:0] o, input logic [1:0] s, output int cyc);
        @(negedge clk);
        start = 1'b1; op = o; pair_sel = s;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) chk("R8 watchdog done", 32'd0, 32'd1);
    endtask

    // Pair-add vectors: {sel, hl, pair, exp_hl, exp_cy}.
    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] hl;
        logic [15:0] pr;
        logic [15:0] exp_hl;
        logic        exp_cy;
    } add_vec_t;
    localparam add_vec_t ADD_TAB [0:5] = '{
        '{2'd0, 16'h1234, 16'h1111, 16'h2345, 1'b0},
        '{2'd1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1},
        '{2'd2, 16'h8000, 16'h8000, 16'h0000, 1'b1},
        '{2'd2, 16'h4321, 16'h4321, 16'h8642, 1'b0},
        '{2'd3, 16'hF000, 16'h2000, 16'h1000, 1'b1},
        '{2'd0, 16'h0000, 16'h0000, 16'h0000, 1'b0}
    };

    initial begin
        int cyc;
        int extra;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 mem_req", mem_req, 0);
        chk("R10 regs", {reg_a, reg_b, reg_c, reg_d, reg_e, reg_h, reg_l}, 0);
        chk("R10 sp_cy", {reg_sp, flag_cy}, 0);
        rst_n = 1'b1;

        // R7: pair add table walk
        for (int i = 0; i < 6; i++) begin
            wr(4'd8, {15'd0, ~ADD_TAB[i].exp_cy});
            wr(4'd5, {8'd0, ADD_TAB[i].hl[15:8]});
            wr(4'd6, {8'd0, ADD_TAB[i].hl[7:0]});
            case (ADD_TAB[i].sel)
                2'd0: begin wr(4'd1, {8'd0, ADD_TAB[i].pr[15:8]}); wr(4'd2, {8'd0, ADD_TAB[i].pr[7:0]}); end
                2'd1: begin wr(4'd3, {8'd0, ADD_TAB[i].pr[15:8]}); wr(4'd4, {8'd0, ADD_TAB[i].pr[7:0]}); end
                2'd3: wr(4'd7, ADD_TAB[i].pr);
                default: ;
            endcase
            run(3'd4, ADD_TAB[i].sel, cyc);
            chk("R7 hl", {reg_h, reg_l}, ADD_TAB[i].exp_hl);
            chk("R7 carry", flag_cy, ADD_TAB[i].exp_cy);
        end

        // R1 and R8: pair exchange, busy and done timing
        wr(4'd5, 16'h12); wr(4'd6, 16'h34); wr(4'd3, 16'h56); wr(4'd4, 16'h78);
        @(negedge clk);
        start = 1'b1; op = 3'd0;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", busy, 1);
        chk("R8 done not yet", done, 0);
        @(negedge clk);
        chk("R8 done raised", done, 1);
        chk("R8 busy cleared", busy, 0);
        chk("R1 hl", {reg_h, reg_l}, 16'h5678);
        chk("R1 de", {reg_d, reg_e}, 16'h1234);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);

        // R2: stack pointer load
        wr(4'd5, 16'hBE); wr(4'd6, 16'hEF);
        run(3'd1, 2'd0, cyc);
        chk("R2 sp", reg_sp, 16'hBEEF);
        chk("R2 hl kept", {reg_h, reg_l}, 16'hBEEF);

        // R3, R4: stack-top exchange with slow memory
        lat = 2;
        wr(4'd7, 16'h0100); wr(4'd5, 16'h22); wr(4'd6, 16'h11);
        mem[8'h00] = 8'hA5; mem[8'h01] = 8'h5A;
        log_n = 0;
        run(3'd2, 2'd0, cyc);
        chk("R3 step count", log_n, 4);
        chk("R3 step0", {log_addr[0], 7'd0, log_we[0]}, {16'h0100, 8'h00});
        chk("R3 step1", {log_addr[1], 7'd0, log_we[1]}, {16'h0101, 8'h00});
        chk("R3 step2", {log_addr[2], 7'd0, log_we[2], log_data[2]}, {16'h0100, 8'h01, 8'h11});
        chk("R3 step3", {log_addr[3], 7'd0, log_we[3], log_data[3]}, {16'h0101, 8'h01, 8'h22});
        chk("R3 sp kept", reg_sp, 16'h0100);
        chk("R4 hl", {reg_h, reg_l}, 16'h5AA5);

        // R5: wrap of the second stack address
        lat = 0;
        wr(4'd7, 16'hFFFF); wr(4'd5, 16'h44); wr(4'd6, 16'h33);
        mem[8'hFF] = 8'h77; mem[8'h00] = 8'h88;
        log_n = 0;
        run(3'd2, 2'd0, cyc);
        chk("R5 second addr", log_addr[1], 16'h0000);
        chk("R5 hl", {reg_h, reg_l}, 16'h8877);
        chk("R5 mem", {mem[8'hFF], mem[8'h00]}, 16'h3344);

        // R6: indirect store through BC then DE
        wr(4'd0, 16'h9C); wr(4'd1, 16'h02); wr(4'd2, 16'h10);
        wr(4'd3, 16'h03); wr(4'd4, 16'h20);
        log_n = 0;
        run(3'd3, 2'd0, cyc);
        chk("R6 bc addr", log_addr[0], 16'h0210);
        chk("R6 bc data", mem[8'h10], 8'h9C);
        run(3'd3, 2'd1, cyc);
        chk("R6 de addr", log_addr[1], 16'h0320);
        chk("R6 de data", mem[8'h20], 8'h9C);
        chk("R6 a kept", reg_a, 8'h9C);

        // R12: undefined operation code
        run(3'd6, 2'd0, cyc);
        chk("R12 regs kept", {reg_a, reg_d, reg_e, reg_h, reg_l}, {8'h9C, 8'h03, 8'h20, 8'h88, 8'h77});
        chk("R12 sp kept", reg_sp, 16'hFFFF);

        // R8, R11: start and register write during a busy exchange
        lat = 3;
        wr(4'd7, 16'h0040); wr(4'd1, 16'h5B);
        @(negedge clk);
        start = 1'b1; op = 3'd2;
        @(negedge clk);
        start = 1'b1; op = 3'd0;
        reg_wr_en = 1'b1; reg_wr_idx = 4'd1; reg_wr_data = 16'h00EE;
        @(negedge clk);
        start = 1'b0; reg_wr_en = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        chk("R8 busy op finished", done, 1);
        extra = 0;
        for (int i = 0; i < 5; i++) begin @(negedge clk); if (done) extra++; end
        chk("R8 start ignored", extra, 0);
        chk("R8 de untouched", {reg_d, reg_e}, 16'h0320);
        chk("R11 write ignored", reg_b, 8'h5B);

        // R10: reset clears state after activity
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R10 regs after reset", {reg_sp, reg_h, reg_l, 7'd0, flag_cy}, 0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule